// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a processor-facing register port and the shift engine of an SPI controller. It stores outgoing and incoming words in two first-in first-out queues of sixteen entries each. Software fills the transmit queue through a data register. The shift engine drains that queue with a pop strobe. Words the engine receives are pushed into the receive queue, and software drains them through a second data register.

Eight conditions about the two queues and the transfer are gathered into a status register. Each condition has an enable bit at the same position in an enable register. A single interrupt line is raised whenever an enabled condition is true. Two of the conditions are sticky and are cleared by writing one: transfer complete and receive overflow. A control register reports both fill counts, and writing to it can flush either queue on its own.

Register map (word address on `busAddr`): 0 transmit data (write), 1 receive data (read), 2 status, 3 interrupt enable, 4 fill counts (read) / flush (write). All other addresses read as zero.

Top module: `spi_fifo_stat_top`

## Requirements
- R1: Status register bits are: bit 0 TX empty (TX count 0), bit 1 TX half-full, bit 2 TX full (TX count 16), bit 3 RX ready (RX count at least 1), bit 4 RX half-full, bit 5 RX full (RX count 16), bit 6 RX overflow, bit 7 transfer complete.
- R2: `irq` is high exactly when the bitwise AND of the status bits and the 8-bit enable register is nonzero.
- R3: A half-full bit is set when its queue holds 8 or more words, and it is clear below 8.
- R4: A one-cycle `engXferDone` pulse sets status bit 7. The bit stays set until a status write with bit 7 at one. A status write with bit 7 at zero leaves it set.
- R5: Address 4 reads the TX fill count in bits 4:0 and the RX fill count in bits 9:5.
- R6: A write to address 4 with bit 10 set empties the TX queue. A write with bit 11 set empties the RX queue. Each bit leaves the other queue untouched.
- R7: A receive push while the RX queue is full discards the word and sets status bit 6. Bit 6 stays set until a status write with bit 6 at one.
- R8: A write to address 0 while the TX queue is full is ignored. A read of address 1 while the RX queue is empty returns zero and changes nothing.
- R9: Words leave each queue in the order they entered. TX words appear on `engTxWord`, and RX words appear on reads of address 1. `engTxWord` is zero when the TX queue is empty.
- R10: Address 3 is a read/write 8-bit enable register that resets to zero. After reset the status reads 0x01 and both counts read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe (pops on address 1) |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register (combinational) |
| engTxPop | input | 1 | Shift engine takes the head TX word |
| engTxWord | output | 32 | Head of the TX queue, zero when empty |
| engRxPush | input | 1 | Shift engine delivers a received word |
| engRxWord | input | 32 | Received word |
| engXferDone | input | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request |

## Verification
A fill counter that drifts from its storage pointers shows up on the next read of address 4. It also shows up in the status flags on the same cycle, because empty, ready, half-full and full are decoded from those counts without any register in between. A lost sticky bit or a wrong enable position appears on `irq` in the cycle after the event. A wrong pointer wrap shows up only when a queue is filled past its last slot and drained, so the bench fills both queues completely and checks every word in order. It also pushes one word past full to make sure that word is dropped.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [2:0] ADDR_TXD  = 3'd0;
  localparam logic [2:0] ADDR_RXD  = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;
  localparam logic [2:0] ADDR_IEN  = 3'd3;
  localparam logic [2:0] ADDR_CNT  = 3'd4;

  localparam int ST_TXE  = 0;
  localparam int ST_TXH  = 1;
  localparam int ST_TXF  = 2;
  localparam int ST_RXR  = 3;
  localparam int ST_RXH  = 4;
  localparam int ST_RXF  = 5;
  localparam int ST_OVF  = 6;
  localparam int ST_DONE = 7;
  localparam int ST_W    = 8;

  localparam int CNT_FIELD_W = 5;
  localparam int FLUSH_TX_BIT = 10;
  localparam int FLUSH_RX_BIT = 11;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoCmd_t;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop)  rdPtr <= nextPtr(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wdata;
  end

  assign head = (count == '0) ? '0 : mem[rdPtr];

  // Guards on the strobes the control block issues
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (count != FULL_CNT));
  a_r8_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> (count != '0));
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0));
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          cmd,
  input  logic [DATA_W-1:0] txWdata,
  input  logic [DATA_W-1:0] rxWdata,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) txBuf_i (
    .clk(clk), .rstN(rstN),
    .push(cmd.txPush), .pop(cmd.txPop), .flush(cmd.txFlush),
    .wdata(txWdata), .head(txHead), .count(txCount)
  );

  spi_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) rxBuf_i (
    .clk(clk), .rstN(rstN),
    .push(cmd.rxPush), .pop(cmd.rxPop), .flush(cmd.rxFlush),
    .wdata(rxWdata), .head(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              engXferDone,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [DATA_W-1:0] rxHead,
  output fifoCmd_t          cmd,
  output logic              irq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  logic [ST_W-1:0] enableReg;
  logic [ST_W-1:0] status;
  logic            doneFlag, ovfFlag;
  logic            txFull, rxFull, txEmpty, rxEmpty;
  logic            statWr, ienWr, cntWr;

  assign txFull  = (txCount == FULL_CNT);
  assign rxFull  = (rxCount == FULL_CNT);
  assign txEmpty = (txCount == '0);
  assign rxEmpty = (rxCount == '0);

  assign statWr = busWr && (busAddr == ADDR_W'(ADDR_STAT));
  assign ienWr  = busWr && (busAddr == ADDR_W'(ADDR_IEN));
  assign cntWr  = busWr && (busAddr == ADDR_W'(ADDR_CNT));

  always_comb begin
    cmd         = '0;
    cmd.txFlush = cntWr && busWdata[FLUSH_TX_BIT];
    cmd.rxFlush = cntWr && busWdata[FLUSH_RX_BIT];
    cmd.txPush  = busWr && (busAddr == ADDR_W'(ADDR_TXD)) && !txFull && !cmd.txFlush;
    cmd.txPop   = engTxPop && !txEmpty && !cmd.txFlush;
    cmd.rxPush  = engRxPush && !rxFull && !cmd.rxFlush;
    cmd.rxPop   = busRd && (busAddr == ADDR_W'(ADDR_RXD)) && !rxEmpty && !cmd.rxFlush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableReg <= '0;
      doneFlag  <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (ienWr) enableReg <= busWdata[ST_W-1:0];
      if (engXferDone)                    doneFlag <= 1'b1;
      else if (statWr && busWdata[ST_DONE]) doneFlag <= 1'b0;
      if (engRxPush && rxFull)            ovfFlag <= 1'b1;
      else if (statWr && busWdata[ST_OVF])  ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TXE]  = txEmpty;
    status[ST_TXH]  = (txCount >= HALF_CNT);
    status[ST_TXF]  = txFull;
    status[ST_RXR]  = !rxEmpty;
    status[ST_RXH]  = (rxCount >= HALF_CNT);
    status[ST_RXF]  = rxFull;
    status[ST_OVF]  = ovfFlag;
    status[ST_DONE] = doneFlag;
  end

  assign irq = |(status & enableReg);

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(ADDR_RXD):  busRdata = rxHead;
      ADDR_W'(ADDR_STAT): busRdata = DATA_W'(status);
      ADDR_W'(ADDR_IEN):  busRdata = DATA_W'(enableReg);
      ADDR_W'(ADDR_CNT):  busRdata = DATA_W'(txCount) | (DATA_W'(rxCount) << CNT_FIELD_W);
      default:            busRdata = '0;
    endcase
  end

  a_r4_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    engXferDone |=> doneFlag);
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(statWr && busWdata[ST_DONE])) |=> doneFlag);
  a_r7_ovf_sets: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxFull) |=> ovfFlag);
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(statWr && busWdata[ST_OVF])) |=> ovfFlag);
  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (enableReg != '0));
  a_r8_rx_pop_full_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && engRxPush && !busRd && !cntWr) |=> rxFull);
endmodule

// File: rtl/spi_fifo_stat_top.sv
module spi_fifo_stat_top
  import spi_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              engTxPop,
  output logic [DATA_W-1:0] engTxWord,
  input  logic              engRxPush,
  input  logic [DATA_W-1:0] engRxWord,
  input  logic              engXferDone,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCmd_t          cmd;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [DATA_W-1:0] rxHead;

  spi_fifo_ctl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rstN(rstN),
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engXferDone(engXferDone),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .cmd(cmd), .irq(irq)
  );

  spi_fifo_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd),
    .txWdata(busWdata), .rxWdata(engRxWord),
    .txHead(engTxWord), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: tb/spi_fifo_stat_top_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_stat_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        engTxPop = 1'b0, engRxPush = 1'b0, engXferDone = 1'b0;
  logic [31:0] engTxWord, engRxWord = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_fifo_stat_top dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .engTxPop(engTxPop),
    .engTxWord(engTxWord), .engRxPush(engRxPush), .engRxWord(engRxWord),
    .engXferDone(engXferDone), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1 busWr = 1'b0;
  endtask

  task automatic busReadChk(input logic [2:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    #1 chk(req, busRdata, exp);
    @(posedge clk); #1 busRd = 1'b0;
  endtask

  task automatic rxPush(input logic [31:0] d);
    @(negedge clk); engRxPush = 1'b1; engRxWord = d;
    @(posedge clk); #1 engRxPush = 1'b0;
  endtask

  task automatic txPopChk(input logic [31:0] exp, input string req);
    @(negedge clk); engTxPop = 1'b1;
    #1 chk(req, engTxWord, exp);
    @(posedge clk); #1 engTxPop = 1'b0;
  endtask

  task automatic irqChk(input logic exp, input string req);
    @(negedge clk); #1 chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic donePulse();
    @(negedge clk); engXferDone = 1'b1;
    @(posedge clk); #1 engXferDone = 1'b0;
  endtask

  // kind: 0 write, 1 read-check, 2 rx push, 3 tx pop check, 4 irq check
  localparam int NV = 23;
  localparam logic [73:0] VEC [NV] = '{
    {3'd1, 3'd2, 32'h0,  32'h01, 4'd1},  // R1 status after reset
    {3'd0, 3'd0, 32'hA1, 32'h0,  4'd9},
    {3'd0, 3'd0, 32'hB2, 32'h0,  4'd9},
    {3'd1, 3'd4, 32'h0,  32'h02, 4'd5},  // R5 tx count
    {3'd1, 3'd2, 32'h0,  32'h00, 4'd1},  // R1 not empty
    {3'd3, 3'd0, 32'h0,  32'hA1, 4'd9},  // R9 order
    {3'd3, 3'd0, 32'h0,  32'hB2, 4'd9},
    {3'd1, 3'd2, 32'h0,  32'h01, 4'd1},
    {3'd2, 3'd0, 32'h11, 32'h0,  4'd9},
    {3'd2, 3'd0, 32'h22, 32'h0,  4'd9},
    {3'd1, 3'd4, 32'h0,  32'h40, 4'd5},  // R5 rx count in 9:5
    {3'd1, 3'd2, 32'h0,  32'h09, 4'd1},  // R1 rx ready
    {3'd1, 3'd1, 32'h0,  32'h11, 4'd9},
    {3'd1, 3'd1, 32'h0,  32'h22, 4'd9},
    {3'd1, 3'd1, 32'h0,  32'h00, 4'd8},  // R8 empty read gives zero
    {3'd1, 3'd4, 32'h0,  32'h00, 4'd8},
    {3'd0, 3'd3, 32'h08, 32'h0,  4'd10},
    {3'd1, 3'd3, 32'h0,  32'h08, 4'd10}, // R10 enable readback
    {3'd2, 3'd0, 32'h33, 32'h0,  4'd2},
    {3'd4, 3'd0, 32'h0,  32'h01, 4'd2},  // R2 irq on rx ready
    {3'd1, 3'd1, 32'h0,  32'h33, 4'd9},
    {3'd4, 3'd0, 32'h0,  32'h00, 4'd2},  // R2 irq drops
    {3'd0, 3'd3, 32'h00, 32'h0,  4'd10}
  };

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R10 reset state
    busReadChk(3'd2, 32'h01, "R10");
    busReadChk(3'd3, 32'h00, "R10");
    busReadChk(3'd4, 32'h00, "R10");
    irqChk(1'b0, "R10");
    chk("R9", engTxWord, 32'h0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][3:0]);
      case (VEC[i][73:71])
        3'd0: busWrite(VEC[i][70:68], VEC[i][67:36]);
        3'd1: busReadChk(VEC[i][70:68], VEC[i][35:4], rq);
        3'd2: rxPush(VEC[i][67:36]);
        3'd3: txPopChk(VEC[i][35:4], rq);
        default: irqChk(VEC[i][4], rq);
      endcase
    end

    // R3 / R1 / R8: fill the TX queue
    for (int i = 0; i < 7; i++) busWrite(3'd0, 32'h100 + i);
    busReadChk(3'd2, 32'h00, "R3");
    busWrite(3'd0, 32'h107);
    busReadChk(3'd2, 32'h02, "R3");
    for (int i = 8; i < 16; i++) busWrite(3'd0, 32'h100 + i);
    busReadChk(3'd2, 32'h06, "R1");
    busWrite(3'd0, 32'hDEAD);
    busReadChk(3'd4, 32'd16, "R8");
    for (int i = 0; i < 16; i++) txPopChk(32'h100 + i, "R9");
    chk("R9", engTxWord, 32'h0);
    busReadChk(3'd2, 32'h01, "R1");

    // R3 / R7: fill the RX queue and overflow it
    for (int i = 0; i < 8; i++) rxPush(32'h200 + i);
    busReadChk(3'd2, 32'h19, "R3");
    for (int i = 8; i < 16; i++) rxPush(32'h200 + i);
    busReadChk(3'd2, 32'h39, "R1");
    rxPush(32'hBAD);
    busReadChk(3'd2, 32'h79, "R7");
    busReadChk(3'd4, 32'h200, "R7");
    busWrite(3'd2, 32'h00);
    busReadChk(3'd2, 32'h79, "R7");
    busWrite(3'd2, 32'h40);
    busReadChk(3'd2, 32'h39, "R7");
    for (int i = 0; i < 16; i++) busReadChk(3'd1, 32'h200 + i, "R9");
    busReadChk(3'd1, 32'h0, "R8");

    // R6: independent flushes
    rxPush(32'h1); rxPush(32'h2); rxPush(32'h3);
    busWrite(3'd0, 32'h5); busWrite(3'd0, 32'h6);
    busReadChk(3'd4, 32'h62, "R6");
    busWrite(3'd4, 32'h800);
    busReadChk(3'd4, 32'h02, "R6");
    chk("R6", engTxWord, 32'h5);
    busWrite(3'd4, 32'h400);
    busReadChk(3'd4, 32'h00, "R6");
    busReadChk(3'd2, 32'h01, "R6");

    // R4: sticky transfer complete
    donePulse();
    busReadChk(3'd2, 32'h81, "R4");
    busWrite(3'd2, 32'h7F);
    busReadChk(3'd2, 32'h81, "R4");
    busWrite(3'd3, 32'h80);
    irqChk(1'b1, "R4");
    busWrite(3'd2, 32'h80);
    busReadChk(3'd2, 32'h01, "R4");
    irqChk(1'b0, "R4");

    // R2: enable positions must match
    busWrite(3'd3, 32'h02);
    irqChk(1'b0, "R2");
    busWrite(3'd3, 32'h01);
    irqChk(1'b1, "R2");
    busWrite(3'd3, 32'h00);
    irqChk(1'b0, "R2");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule